// File: doc/BRIEF.md
# Data-Processing Second-Operand Shifter

This block forms the second operand of a 32-bit data-processing instruction together with the carry that a flag-setting logical operation would take. It is purely combinational. The caller supplies four inputs: the immediate-form flag, the low twelve bits of the instruction word, the value already read from the shifted register, and the low byte of the shift-amount register. The caller also supplies the current carry flag. The block returns the operand and the shifter carry in the same cycle.

Two encodings are handled. In the immediate form, an 8-bit constant is rotated right by an even amount. In the register form, the register value is shifted left logically, right logically, right arithmetically, or rotated. The amount comes from a 5-bit instruction field or from the amount register's low byte. The zero and large amounts carry the special meanings the instruction set gives them: an immediate zero can mean thirty-two or a one-bit rotate through carry, a register amount of zero keeps the carry, and amounts of thirty-two and above saturate.

Top module: `shift_operand`

## Requirements
- R1: With `sel_imm`=1, `opnd` equals `enc[7:0]` zero-extended and rotated right by 2*`enc[11:8]`. `carry_out` equals `carry_in` when `enc[11:8]`=0 and equals `opnd[31]` otherwise.
- R2: With `sel_imm`=0, the shift kind is `enc[6:5]`, where 00=LSL, 01=LSR, 10=ASR and 11=ROR. `enc[4]`=0 takes the amount from `enc[11:7]`, and `enc[4]`=1 takes it from `rs_low`.
- R3: An immediate LSL by 0 passes `rm_val` through and keeps `carry_in`. An immediate LSL by n in 1..31 gives `rm_val<<n`, with carry `rm_val[32-n]`.
- R4: An immediate LSR by 0 acts as a shift by 32 and gives 0 with carry `rm_val[31]`. An immediate ASR by 0 gives 32 copies of `rm_val[31]` with carry `rm_val[31]`.
- R5: An immediate ROR by 0 is a one-bit rotate through carry: `opnd`={`carry_in`,`rm_val[31:1]`} and `carry_out`=`rm_val[0]`.
- R6: With a register amount, `rs_low`=0 gives `opnd`=`rm_val` and `carry_out`=`carry_in` for every shift kind.
- R7: A register LSL or LSR by exactly 32 gives 0, with carry `rm_val[0]` for LSL and `rm_val[31]` for LSR. A register LSL or LSR by 33..255 gives 0 with carry 0.
- R8: A register ASR by 32..255 gives 32 copies of `rm_val[31]` with carry `rm_val[31]`.
- R9: A register ROR rotates by `rs_low` modulo 32. When `rs_low[4:0]`=0 but `rs_low` is nonzero, `opnd`=`rm_val` and `carry_out`=`rm_val[31]`.
- R10: For any other right shift or rotate by n, `opnd` is the shifted or rotated value and `carry_out` is `rm_val[n-1]`. A register LSL by n in 1..31 gives carry `rm_val[32-n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_imm | input | 1 | 1 selects the rotated 8-bit immediate form |
| enc | input | 12 | Low twelve bits of the instruction word |
| rm_val | input | W | Value of the register being shifted |
| rs_low | input | AW | Low byte of the shift-amount register |
| carry_in | input | 1 | Current carry flag |
| opnd | output | W | Shifted second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Two special meanings can meet on one input vector. A zero or saturating amount can coincide with a carry rule, for example an immediate rotate of zero selecting the rotate through carry, or a register amount whose low five bits are zero while its upper bits are not. These collisions are provoked both by directed vectors and by random vectors. The random vectors bias the amount byte toward 0, 32 and multiples of 32. Each vector is judged against a bench model that shifts one bit at a time, so that saturation and carry selection arise from iteration rather than from a formula.

// File: rtl/shift_operand.sv
module shift_operand #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          sel_imm,
  input  logic [11:0]   enc,
  input  logic [W-1:0]  rm_val,
  input  logic [AW-1:0] rs_low,
  input  logic          carry_in,
  output logic [W-1:0]  opnd,
  output logic          carry_out
);
  localparam int SW = $clog2(W);

  logic [1:0]          kind;
  logic                by_reg;
  logic [AW-1:0]       amt;
  logic [W:0]          wide_l;
  logic [W:0]          wide_r;
  logic signed [W:0]   wide_a;
  logic [2*W-1:0]      rr;
  logic [W-1:0]        konst;
  logic [2*W-1:0]      rr_k;

  assign kind   = enc[6:5];
  assign by_reg = enc[4];
  assign amt    = by_reg ? rs_low : {{(AW-5){1'b0}}, enc[11:7]};
  assign wide_l = {1'b0, rm_val} << amt;
  assign wide_r = {rm_val, 1'b0} >> amt;
  assign wide_a = $signed({rm_val, 1'b0}) >>> amt;
  assign rr     = {rm_val, rm_val} >> amt[SW-1:0];
  assign konst  = {{(W-8){1'b0}}, enc[7:0]};
  assign rr_k   = {konst, konst} >> {enc[11:8], 1'b0};

  always_comb begin
    opnd      = rm_val;
    carry_out = carry_in;
    if (sel_imm) begin
      opnd      = rr_k[W-1:0];
      carry_out = (enc[11:8] == 4'd0) ? carry_in : rr_k[W-1];
    end else begin
      case (kind)
        2'b00: if (amt != '0) {carry_out, opnd} = wide_l;
        2'b01: begin
          if (!by_reg && amt == '0) begin
            opnd      = '0;
            carry_out = rm_val[W-1];
          end else if (amt != '0) begin
            {opnd, carry_out} = wide_r;
          end
        end
        2'b10: begin
          if (!by_reg && amt == '0) begin
            opnd      = {W{rm_val[W-1]}};
            carry_out = rm_val[W-1];
          end else if (amt != '0) begin
            {opnd, carry_out} = wide_a;
          end
        end
        default: begin
          if (!by_reg && amt == '0) begin
            opnd      = {carry_in, rm_val[W-1:1]};
            carry_out = rm_val[0];
          end else if (amt != '0) begin
            opnd      = rr[W-1:0];
            carry_out = rr[W-1];
          end
        end
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({sel_imm, enc, rm_val, rs_low, carry_in})) begin
      if (sel_imm && enc[11:8] == 4'd0)
        AST_IMM_NOROT: assert (opnd == konst && carry_out == carry_in); // R1
      if (!sel_imm && !enc[4] && enc[6:5] == 2'b11 && enc[11:7] == 5'd0)
        AST_RRX: assert (opnd == {carry_in, rm_val[W-1:1]} && carry_out == rm_val[0]); // R5
      if (!sel_imm && enc[4] && rs_low == '0)
        AST_REG_ZERO_KEEP: assert (opnd == rm_val && carry_out == carry_in); // R6
      if (!sel_imm && enc[4] && !enc[6] && rs_low > AW'(W))
        AST_LOGIC_SAT: assert (opnd == '0 && carry_out == 1'b0); // R7
      if (!sel_imm && enc[4] && enc[6:5] == 2'b10 && rs_low >= AW'(W))
        AST_ASR_FILL: assert (opnd == {W{rm_val[W-1]}} && carry_out == rm_val[W-1]); // R8
      if (!sel_imm && enc[4] && enc[6:5] == 2'b11 && rs_low != '0)
        AST_ROR_CARRY: assert (carry_out == opnd[W-1]); // R9
    end
  end
endmodule

// File: tb/shift_operand_bench.sv
module shift_operand_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_imm;
  logic [11:0] enc;
  logic [31:0] rm_val;
  logic [7:0]  rs_low;
  logic        carry_in;
  logic [31:0] opnd;
  logic        carry_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_operand u_shift_operand (
    .sel_imm(sel_imm), .enc(enc), .rm_val(rm_val), .rs_low(rs_low),
    .carry_in(carry_in), .opnd(opnd), .carry_out(carry_out)
  );

  function automatic logic [32:0] model(input logic si, input logic [11:0] e,
                                        input logic [31:0] r, input logic [7:0] s,
                                        input logic c);
    logic [31:0] v;
    logic        co;
    int          n;
    v  = r;
    co = c;
    if (si) begin
      v = {24'd0, e[7:0]};
      for (int i = 0; i < 2*e[11:8]; i++) v = {v[0], v[31:1]};
      if (e[11:8] != 0) co = v[31];
    end else begin
      n = e[4] ? int'(s) : int'(e[11:7]);
      case (e[6:5])
        2'b00: for (int i = 0; i < n; i++) begin co = v[31]; v = v << 1; end
        2'b01: begin
          if (!e[4] && n == 0) n = 32;
          for (int i = 0; i < n; i++) begin co = v[0]; v = v >> 1; end
        end
        2'b10: begin
          if (!e[4] && n == 0) n = 32;
          for (int i = 0; i < n; i++) begin co = v[0]; v = {v[31], v[31:1]}; end
        end
        default: begin
          if (!e[4] && n == 0) begin
            co = r[0]; v = {c, r[31:1]};
          end else if (n != 0) begin
            if (n % 32 == 0) co = v[31];
            for (int i = 0; i < n % 32; i++) begin co = v[0]; v = {v[0], v[31:1]}; end
          end
        end
      endcase
    end
    return {co, v};
  endfunction

  task automatic apply(input string tag, input logic si, input logic [11:0] e,
                       input logic [31:0] r, input logic [7:0] s, input logic c);
    logic [32:0] exp;
    @(negedge clk);
    sel_imm = si; enc = e; rm_val = r; rs_low = s; carry_in = c;
    #1;
    exp = model(si, e, r, s, c);
    n_checks++;
    if ({carry_out, opnd} !== exp) begin
      n_fail++;
      $display("FAIL %s: got c=%0b op=%08h expected c=%0b op=%08h", tag,
               carry_out, opnd, exp[32], exp[31:0]);
    end
  endtask

  function automatic logic [11:0] renc(input logic [1:0] k, input logic [4:0] a, input logic reg_amt);
    return {a, k, reg_amt, 4'h0};
  endfunction

  initial begin
    sel_imm = 0; enc = 0; rm_val = 0; rs_low = 0; carry_in = 0;
    repeat (3) @(posedge clk);
    rst = 0;
    apply("R3 reset-idle zeros", 0, 12'h000, 32'h0, 8'h0, 1'b1);
    apply("R1 imm no rotate", 1, 12'h0A5, 32'hDEADBEEF, 8'h0, 1'b1);
    apply("R1 imm rotate 2", 1, 12'h1FF, 32'h0, 8'h0, 1'b0);
    apply("R1 imm rotate 30", 1, 12'hF81, 32'h0, 8'h0, 1'b1);
    apply("R3 lsl imm 0", 0, renc(2'b00, 5'd0, 0), 32'h80000001, 8'hFF, 1'b1);
    apply("R3 lsl imm 1", 0, renc(2'b00, 5'd1, 0), 32'h80000001, 8'h0, 1'b0);
    apply("R3 lsl imm 31", 0, renc(2'b00, 5'd31, 0), 32'h00000003, 8'h0, 1'b0);
    apply("R4 lsr imm 0", 0, renc(2'b01, 5'd0, 0), 32'h80000000, 8'h0, 1'b0);
    apply("R4 asr imm 0", 0, renc(2'b10, 5'd0, 0), 32'h80001234, 8'h0, 1'b0);
    apply("R4 asr imm 0 pos", 0, renc(2'b10, 5'd0, 0), 32'h7FFFFFFF, 8'h0, 1'b1);
    apply("R5 rrx c=1", 0, renc(2'b11, 5'd0, 0), 32'h00000003, 8'h0, 1'b1);
    apply("R5 rrx c=0", 0, renc(2'b11, 5'd0, 0), 32'hFFFFFFFE, 8'h0, 1'b0);
    for (int k = 0; k < 4; k++)
      apply("R6 reg amount 0", 0, renc(k[1:0], 5'd3, 1), 32'h12345678, 8'h0, 1'b1);
    apply("R7 reg lsl 32", 0, renc(2'b00, 5'd0, 1), 32'h00000001, 8'd32, 1'b0);
    apply("R7 reg lsr 32", 0, renc(2'b01, 5'd0, 1), 32'h80000000, 8'd32, 1'b0);
    apply("R7 reg lsl 33", 0, renc(2'b00, 5'd0, 1), 32'hFFFFFFFF, 8'd33, 1'b1);
    apply("R7 reg lsr 255", 0, renc(2'b01, 5'd0, 1), 32'hFFFFFFFF, 8'd255, 1'b1);
    apply("R8 reg asr 32", 0, renc(2'b10, 5'd0, 1), 32'h80000000, 8'd32, 1'b0);
    apply("R8 reg asr 200", 0, renc(2'b10, 5'd0, 1), 32'h7FFFFFFF, 8'd200, 1'b1);
    apply("R9 reg ror 32", 0, renc(2'b11, 5'd0, 1), 32'h80000001, 8'd32, 1'b0);
    apply("R9 reg ror 36", 0, renc(2'b11, 5'd0, 1), 32'h000000F8, 8'd36, 1'b0);
    apply("R10 reg lsr 31", 0, renc(2'b01, 5'd0, 1), 32'hC0000000, 8'd31, 1'b0);
    apply("R10 reg lsl 4", 0, renc(2'b00, 5'd0, 1), 32'h1000000F, 8'd4, 1'b0);
    apply("R10 imm ror 8", 0, renc(2'b11, 5'd8, 0), 32'h123456F0, 8'h0, 1'b0);
    apply("R2 imm asr 4", 0, renc(2'b10, 5'd4, 0), 32'h80000018, 8'h0, 1'b0);
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] s;
      logic [11:0] e;
      s = 8'($urandom);
      case ($urandom % 4)
        0: s = 8'd0;
        1: s = 8'd32;
        2: s = {s[7:5], 5'd0};
        default: ;
      endcase
      e = 12'($urandom);
      e[7] = e[4] ? 1'b0 : e[7];
      apply("R2 R10 random", ($urandom % 5) == 0, e, $urandom, s, 1'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule